// File: doc/BRIEF.md
# Byte-Wide SPI Master with CPU Register Port

This block is a serial peripheral interface controller in master mode. It connects to a small synchronous CPU register bus. Software sets up the clock shape and bit rate, enables master operation, and writes one byte to the data register. The block then generates eight serial clock periods on `sck_o`. It drives the byte out on `mosi_o` and samples the incoming byte from `miso_i`.

When the eighth bit completes, the received byte is moved into a holding buffer and a completion flag goes high. The flag can raise an interrupt. Software clears the flag with a two-step access: it reads the status register while the flag is set, then reads the data register.

The `ss_n_i` input protects master operation. A low level on it removes the master and pin-drive enables, stops any transfer in progress and records a mode fault.

Top module: `spi_master_regs`

Register map. Addresses are on `bus_addr`:
- 0 = control: [1:0] rate select, [2] phase, [3] polarity, [4] master, [5] pin drive enable, [6] interrupt enable, [7] interrupt select.
- 1 = prescaler: [4:0] prescale value, [7] extra divide-by-two, [6:5] read/write storage.
- 2 = status: [7] completion flag, [6] mode fault, [0] busy. The other bits read 0.
- 3 = data: a write starts a transfer, a read returns the receive buffer.

## Requirements
- R1: After reset, control, prescaler and status all read 0x00, `sck_o` is low and `irq_o` is low.
- R2: Each serial clock half-period lasts H = (prescale+1) × 2^(rate+1) × (2 if divide-by-two else 1) / 2 system cycles. The completion flag reads 1 exactly 16×H cycles after the clock edge that accepted the data write, and reads 0 one cycle before that.
- R3: The written byte leaves on `mosi_o` most significant bit first. The eight bits taken from `miso_i` are assembled most significant bit first into the receive buffer, and a data-register read returns that buffer.
- R4: While idle, `sck_o` rests at the polarity bit. With phase 0, data is sampled on the first (leading) clock edge of each bit and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: A data write starts a transfer only when both the master bit and the pin drive enable bit are set. Otherwise the write is ignored and busy stays 0.
- R6: A data write during a transfer is ignored, and the byte being shifted is not altered.
- R7: The completion flag clears only when a status read made while the flag is set is followed by a data read. A data read alone leaves the flag at 1.
- R8: While the flag is set and no status read has occurred since it rose, data writes are ignored and start no transfer.
- R9: `irq_o` is 1 exactly when the flag, the interrupt enable bit and the interrupt select bit are all 1.
- R10: A low `ss_n_i` clears the master and pin drive enable bits and aborts a running transfer without setting the flag. If master was set, it also sets the mode-fault bit. A status read clears the mode-fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier; triggers read side effects |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave-select guard |
| pin_oe_o | output | 1 | Drive enable for the serial pins |

## Verification
The completion flag is due 16×H cycles after the accepting write edge, where H is the half-period from R2. Every bench transfer checks the flag at negative edge 16×H−1 (expecting 0) and at negative edge 16×H (expecting 1), with H recomputed in the bench. Control-driven idle levels and ignored writes take effect one register stage later, so they are peeked two negative edges after the write. Bit-order and data checks come from a slave model that follows `sck_o`. The monitor compares the shifted-out byte at the sixteenth clock edge, and the received byte is compared when the data register is read.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_PRESC = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam logic [1:0] ADDR_DATA  = 2'd3;

  typedef struct packed {
    logic       irq_sel;
    logic       irq_en;
    logic       pin_en;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // Half-period in system cycles: (value+1) << rate, doubled when div2 is set.
  function automatic int unsigned half_period(input int unsigned pval,
                                              input logic [1:0] rate,
                                              input logic div2);
    int unsigned shift_amt;
    shift_amt = int'(rate) + (div2 ? 1 : 0);
    return (pval + 1) << shift_amt;
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int HALF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;
  logic              wrap;

  assign wrap = (cnt_q == half - HALF_W'(1));
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [DW-1:0] tx_byte,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int EDGES = 2 * DW;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(EDGES - 1);

  logic [DW-1:0]    shreg_q;
  logic [IDX_W-1:0] idx_q;
  logic             smp_q;
  logic             sample_edge;
  logic             shift_edge;

  assign sample_edge = (idx_q[0] == cpha);
  assign shift_edge  = !sample_edge && !(cpha && idx_q == '0);
  assign done        = busy && tick && !abort && (idx_q == LAST);
  assign mosi        = shreg_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
      smp_q   <= 1'b0;
      rx_byte <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= cpol;
    end else if (start) begin
      busy    <= 1'b1;
      shreg_q <= tx_byte;
      idx_q   <= '0;
      sck     <= cpol;
    end else if (busy && tick) begin
      sck   <= ~sck;
      idx_q <= idx_q + IDX_W'(1);
      if (sample_edge) smp_q <= miso;
      if (shift_edge)  shreg_q <= {shreg_q[DW-2:0], smp_q};
      if (idx_q == LAST) begin
        busy    <= 1'b0;
        rx_byte <= {shreg_q[DW-2:0], (cpha ? miso : smp_q)};
      end
    end else if (!busy) begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_master_pkg::*;
#(
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_n,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output ctrl_t             ctrl,
  output logic [PRESC_W-1:0] presc_val,
  output logic              presc_div2,
  output logic              start,
  output logic              abort,
  output logic              data_rd,
  output logic              armed,
  output logic              flag,
  output logic              fault,
  output logic              irq
);
  logic [DATA_W-1:0] presc_q;
  logic wr_hit, rd_hit, stat_rd, data_wr;

  assign wr_hit  = bus_sel && bus_wr;
  assign rd_hit  = bus_sel && bus_rd;
  assign stat_rd = rd_hit && (bus_addr == ADDR_STAT);
  assign data_rd = rd_hit && (bus_addr == ADDR_DATA);
  assign data_wr = wr_hit && (bus_addr == ADDR_DATA);

  assign presc_val  = presc_q[PRESC_W-1:0];
  assign presc_div2 = presc_q[DATA_W-1];
  assign abort      = !ss_n;
  assign start      = data_wr && ctrl.master && ctrl.pin_en && ss_n && !busy
                      && (!flag || armed);
  assign irq        = flag && ctrl.irq_en && ctrl.irq_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      presc_q <= '0;
    end else begin
      if (!ss_n) begin
        ctrl.master <= 1'b0;
        ctrl.pin_en <= 1'b0;
      end else if (wr_hit && bus_addr == ADDR_CTRL) begin
        ctrl <= ctrl_t'(bus_wdata);
      end
      if (wr_hit && bus_addr == ADDR_PRESC) presc_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      fault <= 1'b0;
    end else begin
      if (done)                   flag <= 1'b1;
      else if (data_rd && armed)  flag <= 1'b0;

      if (data_rd && armed)       armed <= 1'b0;
      else if (flag && stat_rd)   armed <= 1'b1;

      if (!ss_n && ctrl.master)   fault <= 1'b1;
      else if (stat_rd)           fault <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:  bus_rdata = DATA_W'(ctrl);
      ADDR_PRESC: bus_rdata = presc_q;
      ADDR_STAT:  bus_rdata = {flag, fault, {(DATA_W-3){1'b0}}, busy};
      default:    bus_rdata = rx_byte;
    endcase
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_n_i,
  output logic              pin_oe_o
);
  localparam int HALF_W = PRESC_W + 5;

  ctrl_t               ctrl_w;
  logic [PRESC_W-1:0]  presc_val_w;
  logic                presc_div2_w;
  logic [HALF_W-1:0]   half_w;
  logic                tick_w, busy_w, done_w, start_w, abort_w;
  logic                data_rd_w, armed_w, flag_w, fault_w;
  logic [DATA_W-1:0]   rx_w;
  logic                master_w, oe_w, cpol_w;

  assign half_w   = HALF_W'(half_period(int'(presc_val_w), ctrl_w.rate, presc_div2_w));
  assign master_w = ctrl_w.master;
  assign oe_w     = ctrl_w.pin_en;
  assign cpol_w   = ctrl_w.cpol;
  assign pin_oe_o = master_w && oe_w;

  spi_regfile #(.PRESC_W(PRESC_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n(ss_n_i), .busy(busy_w), .done(done_w), .rx_byte(rx_w),
    .ctrl(ctrl_w), .presc_val(presc_val_w), .presc_div2(presc_div2_w),
    .start(start_w), .abort(abort_w), .data_rd(data_rd_w), .armed(armed_w),
    .flag(flag_w), .fault(fault_w), .irq(irq_o)
  );

  spi_baud_gen #(.HALF_W(HALF_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .half(half_w), .tick(tick_w)
  );

  spi_shift_engine #(.DW(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start_w), .abort(abort_w),
    .tx_byte(bus_wdata), .cpol(cpol_w), .cpha(ctrl_w.cpha), .tick(tick_w),
    .miso(miso_i), .busy(busy_w), .sck(sck_o), .mosi(mosi_o),
    .done(done_w), .rx_byte(rx_w)
  );
endmodule

// File: rtl/spi_master_checker.sv
module spi_master_checker (
  input logic clk,
  input logic rst_n,
  input logic flag,
  input logic done,
  input logic data_rd,
  input logic armed,
  input logic irq,
  input logic ss_n,
  input logic master,
  input logic oe,
  input logic busy,
  input logic start,
  input logic sck,
  input logic cpol
);
  assert_flag_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(done));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (sck == $past(cpol)));

  assert_start_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_clear_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(data_rd && armed));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_ss_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |=> (!master && !oe));
endmodule

bind spi_master_regs spi_master_checker chk_i (
  .clk(clk), .rst_n(rst_n), .flag(flag_w), .done(done_w),
  .data_rd(data_rd_w), .armed(armed_w), .irq(irq_o), .ss_n(ss_n_i),
  .master(master_w), .oe(oe_w), .busy(busy_w), .start(start_w),
  .sck(sck_o), .cpol(cpol_w)
);

// File: tb/spi_master_regs_tb.sv
module spi_master_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq_o, sck_o, mosi_o, miso_i, pin_oe_o;
  logic ss_n = 1'b1;

  int checks = 0;
  int failures = 0;

  logic [7:0] slave_tx = 8'd0, slave_rx = 8'd0;
  bit slave_on = 1'b0;
  bit cur_cpha = 1'b0;
  int slave_edges = 0;
  logic [7:0] exp_mosi[$];

  always #10 clk = ~clk;
  assign miso_i = slave_tx[7];

  spi_master_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .ss_n_i(ss_n), .pin_oe_o(pin_oe_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int exp_half(input int pval, input int rate, input bit div2);
    return (pval + 1) * (2 ** (rate + 1)) * (div2 ? 2 : 1) / 2;
  endfunction

  // Slave model and monitor: follows sck_o, pops expected MOSI byte at edge 16.
  always @(sck_o) begin
    if (slave_on) begin
      if ((slave_edges % 2) == int'(cur_cpha)) slave_rx = {slave_rx[6:0], mosi_o};
      else if (!(cur_cpha && slave_edges == 0)) slave_tx = slave_tx << 1;
      slave_edges++;
      if (slave_edges == 16) begin
        slave_on = 1'b0;
        if (exp_mosi.size() == 0) check("R3 unexpected transfer", slave_rx, 8'hxx);
        else check("R3 mosi byte", slave_rx, exp_mosi.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic arm_slave(input logic [7:0] sb, input bit ph);
    slave_tx = sb; slave_rx = 8'd0; slave_edges = 0; cur_cpha = ph; slave_on = 1'b1;
  endtask

  // Driver: pushes expected MOSI byte, checks exact flag timing, reads and checks RX.
  task automatic do_xfer(input logic [7:0] tx, input logic [7:0] sb, input bit ph, input int h);
    logic [7:0] d;
    arm_slave(sb, ph);
    exp_mosi.push_back(tx);
    bus_write(2'd3, tx);
    repeat (16 * h - 1) @(negedge clk);
    peek(2'd2, d); check("R2 flag not yet", {7'd0, d[7]}, 8'd0);
    @(negedge clk);
    peek(2'd2, d); check("R2 flag due", {7'd0, d[7]}, 8'd1);
    bus_read(2'd2, d);
    bus_read(2'd3, d); check("R3 rx buffer", d, sb);
    peek(2'd2, d); check("R7 flag cleared", {7'd0, d[7]}, 8'd0);
  endtask

  task automatic wait_flag;
    logic [7:0] d;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      peek(2'd2, d);
      if (d[7]) break;
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); check("R1 control reset", d, 8'h00);
    peek(2'd1, d); check("R1 prescaler reset", d, 8'h00);
    peek(2'd2, d); check("R1 status reset", d, 8'h00);
    check("R1 sck idle", {7'd0, sck_o}, 8'd0);
    check("R1 irq idle", {7'd0, irq_o}, 8'd0);

    // R5 write ignored without master/pin enable
    bus_write(2'd0, 8'h10);
    bus_write(2'd3, 8'h5A);
    @(negedge clk); peek(2'd2, d); check("R5 no start w/o pin enable", {7'd0, d[0]}, 8'd0);

    // Mode 0, H=1, exact timing and RX
    bus_write(2'd0, 8'h30);
    do_xfer(8'hA5, 8'h3C, 1'b0, exp_half(0, 0, 1'b0));

    // R7 / R8: data read alone does not clear; writes blocked until status read
    arm_slave(8'hC3, 1'b0); exp_mosi.push_back(8'h81);
    bus_write(2'd3, 8'h81);
    wait_flag();
    bus_read(2'd3, d); check("R3 rx read", d, 8'hC3);
    peek(2'd2, d); check("R7 flag held after lone data read", {7'd0, d[7]}, 8'd1);
    bus_write(2'd3, 8'h22);
    @(negedge clk); peek(2'd2, d); check("R8 write blocked", {7'd0, d[0]}, 8'd0);
    bus_read(2'd2, d);
    bus_read(2'd3, d);
    peek(2'd2, d); check("R7 flag cleared by sequence", {7'd0, d[7]}, 8'd0);

    // R4 / R2 / R3 across all four modes with differing rates
    for (int m = 0; m < 4; m++) begin
      bit pol, pha, dv;
      pol = m[1]; pha = m[0]; dv = m[0];
      bus_write(2'd1, {dv, 2'b00, 5'(m)});
      bus_write(2'd0, {4'b0011, pol, pha, 2'(m)});
      @(negedge clk);
      check("R4 idle sck level", {7'd0, sck_o}, {7'd0, pol});
      do_xfer(8'h5A ^ 8'(m * 37), 8'h96 + 8'(m * 11), pha, exp_half(m, m, dv));
      check("R4 sck back to idle", {7'd0, sck_o}, {7'd0, pol});
    end

    // R6 write during transfer ignored
    bus_write(2'd1, 8'h01);
    bus_write(2'd0, 8'h30);
    arm_slave(8'h69, 1'b0); exp_mosi.push_back(8'h96);
    bus_write(2'd3, 8'h96);
    bus_write(2'd3, 8'h00);
    wait_flag();
    @(negedge clk);
    check("R6 all edges seen", 8'(slave_edges), 8'd16);
    bus_read(2'd2, d);
    bus_read(2'd3, d); check("R6 rx after ignored write", d, 8'h69);

    // R9 interrupt gating
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h70);
    arm_slave(8'h0F, 1'b0); exp_mosi.push_back(8'hF0);
    bus_write(2'd3, 8'hF0);
    wait_flag();
    check("R9 irq needs select", {7'd0, irq_o}, 8'd0);
    bus_write(2'd0, 8'hF0);
    @(negedge clk);
    check("R9 irq asserted", {7'd0, irq_o}, 8'd1);
    bus_read(2'd2, d);
    bus_read(2'd3, d);
    @(negedge clk);
    check("R9 irq drops with flag", {7'd0, irq_o}, 8'd0);

    // R10 slave-select drop aborts
    bus_write(2'd1, 8'h8F);
    bus_write(2'd0, 8'h30);
    bus_write(2'd3, 8'hAA);
    repeat (20) @(negedge clk);
    ss_n = 1'b0;
    @(negedge clk);
    ss_n = 1'b1;
    peek(2'd0, d); check("R10 master/pin enable cleared", {6'd0, d[5:4]}, 8'd0);
    peek(2'd2, d); check("R10 fault set, busy cleared", d, 8'h40);
    check("R10 pins released", {7'd0, pin_oe_o}, 8'd0);
    repeat (600) @(negedge clk);
    peek(2'd2, d); check("R10 no flag after abort", {7'd0, d[7]}, 8'd0);
    bus_read(2'd2, d);
    peek(2'd2, d); check("R10 fault cleared by status read", d, 8'h00);

    repeat (4) @(negedge clk);
    check("R3 scoreboard drained", 8'(exp_mosi.size()), 8'd0);
    finish_run();
  end
endmodule